// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

A register-mapped pulse-width modulator with four channels that run fully independently of each other. Each channel divides the input clock in two stages. A 16-bit prescaler produces a tick every (prescale+1) clocks. A 16-bit period counter counts those ticks from 0 up to the divider value. The output is high from the start of every period while the period counter is below the programmed high duration. One period therefore lasts (prescale+1)*(divider+1) clocks, and the output is high for high_duration*(prescale+1) of them.

Software writes the divider, high duration and prescale into staging registers. The running waveform takes new values only when the channel's second register is written with its update bit set. On an enabled channel the new values take effect at the next period boundary, so no period is ever cut short or stretched. On a disabled channel they take effect at once. The enable bit acts at once, and the output polarity is always active high. The bus is a simple synchronous port. A write is taken on the clock edge where the write strobe is high. Read data is registered and is valid in the cycle after the read strobe.

Top module: `pwmx_ctrl`

## Requirements
- R1: After reset every PWM output is low and every register reads back as zero.
- R2: Channel n owns byte addresses 8n (word A) and 8n+4 (word B), selected by address bits [4:3] and bit [2]. Word A holds the divider in bits 15:0 and the high duration in bits 31:16. Word B holds the prescale in bits 15:0, the update strobe in bit 30 and the enable in bit 31. Reads return the staged values one cycle after the read strobe. Bits 30:16 of word B always read as 0.
- R3: While enabled, the output repeats with a period of exactly (prescale+1)*(divider+1) clock cycles.
- R4: At the start of each period the output is high for high_duration*(prescale+1) cycles, then low for the rest of the period.
- R5: A high duration of 0 gives a constant low output. A high duration of divider+1 or more gives a constant high output.
- R6: Writes to word A, and word B writes without the update bit, do not change the running waveform.
- R7: An update written to an enabled channel takes effect at the next period boundary. The period in progress completes with the old settings.
- R8: An update written to a disabled channel takes effect at once, so a later enable starts with those settings.
- R9: While a channel is disabled, its output is low and both of its counters are zero. Enabling it starts a new period at count zero, with the output high when the high duration is non-zero.
- R10: Programming or running one channel has no effect on the waveform of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all counters |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Byte address; bits 1:0 are not decoded |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The hardest case to reach from the ports is an update that arrives partway through a period on a running channel. The old settings must hold until the boundary and then switch with no glitch. The bench starts a channel from a known phase and stages new word A values mid-period. It then checks that the waveform does not change, issues the update at a chosen phase, and compares every cycle against an old-then-new reference. A full sweep of small prescale, divider and high-duration values covers the 0% and 100% corners. Meanwhile a second channel runs free, and its waveform is checked cycle by cycle against its own phase for the whole run.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    localparam int NUM_CH  = 4;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int HI_LSB  = 16;
    localparam int BIT_UPD = 30;
    localparam int BIT_EN  = 31;
    localparam int CH_LSB  = 3;
    localparam int REG_BIT = 2;

    typedef struct packed {
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] pre;
    } chan_cfg_t;

    function automatic logic [DATA_W-1:0] word_a(chan_cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[HI_LSB +: CNT_W] = c.high;
        r[0 +: CNT_W]      = c.div;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] word_b(chan_cfg_t c, logic en);
        logic [DATA_W-1:0] r;
        r = '0;
        r[0 +: CNT_W] = c.pre;
        r[BIT_EN]     = en;
        return r;
    endfunction
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    output logic [DW-1:0]   rd_data,
    output chan_cfg_t       stg_d [NCH],
    output logic [NCH-1:0]  en_q,
    output logic [NCH-1:0]  en_d,
    output logic [NCH-1:0]  upd_d
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    chan_cfg_t        stg_q [NCH];
    logic [CH_W-1:0]  ch_sel;
    logic             sel_b;
    logic             unused_bits;

    assign ch_sel      = addr[CH_LSB +: CH_W];
    assign sel_b       = addr[REG_BIT];
    assign unused_bits = ^{wr_data[BIT_UPD-1:HI_LSB], addr[1:0]};

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            stg_d[i] = stg_q[i];
            en_d[i]  = en_q[i];
            upd_d[i] = 1'b0;
            if (wr_en && (int'(ch_sel) == i)) begin
                if (!sel_b) begin
                    stg_d[i].high = wr_data[HI_LSB +: CNT_W];
                    stg_d[i].div  = wr_data[0 +: CNT_W];
                end else begin
                    stg_d[i].pre  = wr_data[0 +: CNT_W];
                    en_d[i]       = wr_data[BIT_EN];
                    upd_d[i]      = wr_data[BIT_UPD];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) stg_q[i] <= '0;
            en_q    <= '0;
            rd_data <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) stg_q[i] <= stg_d[i];
            en_q <= en_d;
            if (rd_en) begin
                rd_data <= '0;
                for (int i = 0; i < NCH; i++) begin
                    if (int'(ch_sel) == i)
                        rd_data <= sel_b ? word_b(stg_q[i], en_q[i]) : word_a(stg_q[i]);
                end
            end
        end
    end
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        stg_d,
    input  logic             en_q,
    input  logic             en_d,
    input  logic             upd_d,
    output chan_cfg_t        act_q,
    output logic [CNT_W-1:0] pre_cnt,
    output logic [CNT_W-1:0] per_cnt,
    output logic             pwm
);
    chan_cfg_t pend_q;
    logic      pend_v;
    logic      bnd;
    logic      apply_now;

    assign bnd       = en_q && (pre_cnt == act_q.pre) && (per_cnt == act_q.div);
    assign apply_now = !en_q || bnd;
    assign pwm       = en_q && (act_q.high > per_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            per_cnt <= '0;
            act_q   <= '0;
            pend_q  <= '0;
            pend_v  <= 1'b0;
        end else begin
            if (!(en_q && en_d)) begin
                pre_cnt <= '0;
                per_cnt <= '0;
            end else if (pre_cnt == act_q.pre) begin
                pre_cnt <= '0;
                per_cnt <= (per_cnt == act_q.div) ? '0 : per_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end

            if (upd_d) begin
                if (apply_now) begin
                    act_q  <= stg_d;
                    pend_v <= 1'b0;
                end else begin
                    pend_q <= stg_d;
                    pend_v <= 1'b1;
                end
            end else if (pend_v && apply_now) begin
                act_q  <= pend_q;
                pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwmx_ctrl.sv
module pwmx_ctrl
    import pwmx_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    output logic [DW-1:0]   rd_data,
    output logic [NCH-1:0]  pwm_out
);
    chan_cfg_t        stg_d   [NCH];
    chan_cfg_t        act_cfg [NCH];
    logic [CNT_W-1:0] pre_cnt [NCH];
    logic [CNT_W-1:0] per_cnt [NCH];
    logic [NCH-1:0]   en_q;
    logic [NCH-1:0]   en_d;
    logic [NCH-1:0]   upd_d;

    pwmx_regs #(.NCH(NCH), .AW(AW), .DW(DW)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .stg_d   (stg_d),
        .en_q    (en_q),
        .en_d    (en_d),
        .upd_d   (upd_d)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwmx_chan chan_i (
            .clk     (clk),
            .rst     (rst),
            .stg_d   (stg_d[g]),
            .en_q    (en_q[g]),
            .en_d    (en_d[g]),
            .upd_d   (upd_d[g]),
            .act_q   (act_cfg[g]),
            .pre_cnt (pre_cnt[g]),
            .per_cnt (per_cnt[g]),
            .pwm     (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwmx_ctrl_chk.sv
module pwmx_ctrl_chk
    import pwmx_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    rd_data,
    input logic [NCH-1:0]   pwm_out,
    input logic [NCH-1:0]   en_q,
    input chan_cfg_t        act_cfg [NCH],
    input logic [CNT_W-1:0] pre_cnt [NCH],
    input logic [CNT_W-1:0] per_cnt [NCH]
);
    // R2: reserved and strobe bits of word B read as zero
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr[REG_BIT])) |-> (rd_data[BIT_UPD:HI_LSB] == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic bnd;
        assign bnd = en_q[i] && (pre_cnt[i] == act_cfg[i].pre) && (per_cnt[i] == act_cfg[i].div);

        // R9: disabled channel is idle
        a_r9_off_idle: assert property (@(posedge clk) disable iff (rst)
            !en_q[i] |-> (!pwm_out[i] && pre_cnt[i] == '0 && per_cnt[i] == '0));

        // R3: counters stay inside the programmed range
        a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
            en_q[i] |-> (pre_cnt[i] <= act_cfg[i].pre && per_cnt[i] <= act_cfg[i].div));

        // R3: prescaler advances by one when not wrapping
        a_r3_pre_step: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && $past(en_q[i]) && $past(pre_cnt[i] != act_cfg[i].pre))
            |-> (pre_cnt[i] == $past(pre_cnt[i]) + 1'b1));

        // R4: period start is high for a non-zero duration
        a_r4_start_high: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && per_cnt[i] == '0 && act_cfg[i].high != '0) |-> pwm_out[i]);

        // R5: saturated duration is always high
        a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && act_cfg[i].high > act_cfg[i].div) |-> pwm_out[i]);

        // R5: zero duration is always low
        a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
            (act_cfg[i].high == '0) |-> !pwm_out[i]);

        // R7: running settings change only after a period boundary
        a_r7_hold_mid: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && $past(en_q[i]) && !$past(bnd)) |-> $stable(act_cfg[i]));
    end
endmodule

bind pwmx_ctrl pwmx_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .en_q    (en_q),
    .act_cfg (act_cfg),
    .pre_cnt (pre_cnt),
    .per_cnt (per_cnt)
);

// File: tb/pwmx_ctrl_tb.sv
module pwmx_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int e2 = 0;
    bit mon2_on = 1'b0;
    int mism2 = 0;

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;

    pwmx_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit model(int pre, int dv, int high, int k);
        int p;
        p = (pre + 1) * (dv + 1);
        return ((k % p) / (pre + 1)) < high;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(int ch, int wb, logic [31:0] d);
        addr = 5'(ch * 8 + wb * 4);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(int ch, int wb, output logic [31:0] d);
        addr = 5'(ch * 8 + wb * 4);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // R10: free-running channel 2 monitored every cycle
    always @(negedge clk) begin
        if (mon2_on && (pwm_out[2] != model(1, 2, 2, cyc - e2))) mism2++;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(pwm_out == 4'b0, "R1 outputs", int'(pwm_out), 0);
        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 2; w++) begin
                bus_rd(c, w, d);
                check(d == 32'h0, "R1 readback", int'(d), 0);
            end
        end

        // R2: field layout and reserved bits
        bus_wr(3, 0, 32'hABCD_1234);
        bus_wr(3, 1, 32'h3FFF_5678 | EN | UPD);
        bus_rd(3, 0, d);
        check(d == 32'hABCD_1234, "R2 word A", int'(d), 32'hABCD_1234);
        bus_rd(3, 1, d);
        check(d == 32'h8000_5678, "R2 word B", int'(d), 32'h8000_5678);
        bus_wr(3, 1, 32'h0);
        bus_rd(3, 1, d);
        check(d == 32'h0000_0000, "R2 enable clear", int'(d), 0);

        // start background channel 2: pre=1 div=2 high=2
        bus_wr(2, 0, {16'd2, 16'd2});
        bus_wr(2, 1, EN | UPD | 32'd1);
        e2 = cyc;
        mon2_on = 1'b1;

        // R3 R4 R5: sweep on channel 0
        for (int pre = 0; pre < 3; pre++) begin
            for (int dv = 0; dv < 4; dv++) begin
                for (int hi = 0; hi < 6; hi++) begin
                    int p;
                    p = (pre + 1) * (dv + 1);
                    bus_wr(0, 1, 32'h0);
                    bus_wr(0, 0, {16'(hi), 16'(dv)});
                    bus_wr(0, 1, EN | UPD | 32'(pre));
                    bad = 0;
                    for (int k = 0; k < 2 * p; k++) begin
                        if (pwm_out[0] != model(pre, dv, hi, k)) bad++;
                        @(negedge clk);
                    end
                    if (hi == 0 || hi > dv)
                        check(bad == 0, "R5 saturation", bad, 0);
                    else
                        check(bad == 0, "R3 R4 waveform", bad, 0);
                end
            end
        end

        // R6 R7: staged change on running channel 0 (pre=0 div=3 high=2)
        bus_wr(0, 1, 32'h0);
        bus_wr(0, 0, {16'd2, 16'd3});
        bus_wr(0, 1, EN | UPD);
        check(pwm_out[0] == 1'b1, "R9 start high", int'(pwm_out[0]), 1);
        bus_wr(0, 0, {16'd1, 16'd1});
        bad = 0;
        for (int j = 0; j < 4; j++) begin
            if (pwm_out[0] != model(0, 3, 2, 1 + j)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 staged ignored", bad, 0);
        bus_wr(0, 1, EN | UPD);
        bad = 0;
        for (int j = 0; j < 6; j++) begin
            bit e;
            e = (j < 2) ? model(0, 3, 2, 2 + j) : model(0, 1, 1, j - 2);
            if (pwm_out[0] != e) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R7 boundary commit", bad, 0);

        // R8: update while disabled on channel 1
        bus_wr(1, 0, {16'd3, 16'd4});
        bus_wr(1, 1, UPD | 32'd1);
        check(pwm_out[1] == 1'b0, "R9 disabled low", int'(pwm_out[1]), 0);
        bus_wr(1, 0, {16'd1, 16'd1});
        bus_wr(1, 1, EN | 32'd1);
        bad = 0;
        for (int k = 0; k < 23; k++) begin
            if (pwm_out[1] != model(1, 4, 3, k)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R8 immediate commit", bad, 0);

        // R9: disable mid-period, then restart at count zero
        bus_wr(1, 1, 32'd1);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (pwm_out[1] != 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9 held low", bad, 0);
        bus_wr(1, 1, EN | 32'd1);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_out[1] != model(1, 4, 3, k)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9 restart phase", bad, 0);

        // R10: channel 2 undisturbed throughout
        check(mism2 == 0, "R10 independence", mism2, 0);
        check(pwm_out[3] == 1'b0, "R10 idle channel", int'(pwm_out[3]), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule